// File: doc/BRIEF.md
# Bounded-Region FIFO Write Controller

This block is the producer-facing write side of a FIFO whose storage lives in a shared RAM. The FIFO occupies a window of that RAM, given by an inclusive lower and upper address. The window can hold any number of entries, not only a power of two. Data arrives over a valid/ready handshake. The block turns each accepted beat into one memory write strobe, with the current write pointer as the address.

The write pointer is exported to a separate read-side controller. That controller returns its committed read pointer. Fullness and occupancy are judged against this committed pointer, so entries that have been read speculatively but not yet committed cannot be overwritten.

A grant input from an outside arbiter gates every write. This allows several controllers to share one RAM, or the read and write sides of a single-port RAM to take turns.

Top module: `fifo_head_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `wr_ptr` is loaded with `lo_bound`. Right after reset is released, `empty` is 1 and `fill_count` is 0, provided `rd_commit_ptr` equals `lo_bound`.
- R2: `mem_we` is 1 exactly when `in_valid` and `in_ready` are both 1 in the same cycle. In that cycle `mem_addr` equals `wr_ptr` and `mem_wdata` equals `in_data`.
- R3: While `grant` is 0, `in_ready` and `mem_we` are 0 whatever `in_valid` is. A beat offered in such a cycle is not written.
- R4: After a clock edge with a write, `wr_ptr` moves one step through the region. After an edge with no write, `wr_ptr` is unchanged.
- R5: A write at `wr_ptr == hi_bound` moves the pointer to `lo_bound`, not to `hi_bound + 1`.
- R6: `full` is 1 when the next pointer position after `wr_ptr` (with wrap) equals `rd_commit_ptr`. `in_ready` is `grant` and not `full`.
- R7: `empty` is 1 exactly when `wr_ptr` equals `rd_commit_ptr`.
- R8: When `wr_ptr >= rd_commit_ptr`, `fill_count` is `wr_ptr - rd_commit_ptr`. Otherwise it is `(hi_bound - lo_bound + 1) - (rd_commit_ptr - wr_ptr)`.
- R9: A region of N = `hi_bound - lo_bound + 1` slots, for any N including N that is not a power of two, accepts N-1 beats from empty before `full` rises. At that point `fill_count` is N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| grant | input | 1 | Arbiter permission to write the RAM this cycle |
| lo_bound | input | AW | First address of the FIFO region |
| hi_bound | input | AW | Last address of the FIFO region (inclusive) |
| rd_commit_ptr | input | AW | Committed read pointer from the read side |
| in_valid | input | 1 | Producer has a beat |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_data | input | DW | Producer beat |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | AW | RAM write address |
| mem_wdata | output | DW | RAM write data |
| wr_ptr | output | AW | Write pointer exported to the read side |
| full | output | 1 | No slot free |
| empty | output | 1 | No entry held |
| fill_count | output | AW+1 | Entries held between committed read pointer and write pointer |

## Verification
The bench runs several regions, including sizes 7 and 5, a region ending at the top address, a full power-of-two region and a one-slot region. For each region it applies three patterns.

A burst into an empty region with one denied grant shows whether capacity stops at N-1 and whether a write lands while grant is low.

A long mixed pattern uses interleaved valid, grant and commit activity. It wraps the pointer several times, so it separates the wrap target from a plain increment. It also exercises both occupancy formulas, with the write pointer ahead of and behind the read pointer.

A final drain moves only the read pointer. It confirms that empty and the count follow the committed pointer while the write pointer stays put.

// File: rtl/fhc_pkg.sv
// Package: shared defaults and types for the bounded-region FIFO write controller.
package fhc_pkg;
    localparam int FHC_DEF_AW = 4;
    localparam int FHC_DEF_DW = 8;

    // Which occupancy formula applies this cycle.
    typedef enum logic {
        OCC_AHEAD   = 1'b0,
        OCC_WRAPPED = 1'b1
    } occ_case_e;
endpackage

// File: rtl/fhc_ptr_step.sv
// fhc_ptr_step: computes the successor of a pointer inside an inclusive
// address window, returning to the lower bound after the upper bound.
// Assumes lo <= hi and cur lies within the window.
module fhc_ptr_step #(
    parameter int AW = fhc_pkg::FHC_DEF_AW
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic [AW-1:0] nxt,
    output logic          wraps
);
    // Successor with wrap at the upper bound.
    always_comb begin
        wraps = (cur == hi);
        nxt   = wraps ? lo : cur + AW'(1);
    end
endmodule

// File: rtl/fhc_occupancy.sv
// fhc_occupancy: number of entries between a read and a write pointer in a
// window of hi-lo+1 slots. Assumes both pointers lie within the window.
module fhc_occupancy #(
    parameter int AW = fhc_pkg::FHC_DEF_AW
) (
    input  logic [AW-1:0] wptr,
    input  logic [AW-1:0] rptr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic [AW:0]   count
);
    import fhc_pkg::*;

    logic [AW:0] region_size;
    logic [AW:0] gap_fwd;
    logic [AW:0] gap_back;
    occ_case_e   sel;

    // Region size and both pointer distances.
    always_comb begin
        region_size = {1'b0, hi} - {1'b0, lo} + (AW+1)'(1);
        gap_fwd     = {1'b0, wptr} - {1'b0, rptr};
        gap_back    = {1'b0, rptr} - {1'b0, wptr};
        sel         = (wptr >= rptr) ? OCC_AHEAD : OCC_WRAPPED;
    end

    // Pick the formula that matches pointer order.
    always_comb begin
        case (sel)
            OCC_AHEAD:   count = gap_fwd;
            default:     count = region_size - gap_back;
        endcase
    end
endmodule

// File: rtl/fifo_head_ctrl.sv
// fifo_head_ctrl: write-side controller of a RAM-based FIFO confined to the
// window [lo_bound, hi_bound]. Accepts producer beats under valid/ready,
// writes them at the write pointer, and judges fullness against the read
// side's committed pointer. One slot stays free to tell full from empty.
// Assumes bounds are held steady outside reset and lo_bound <= hi_bound.
module fifo_head_ctrl #(
    parameter int AW = fhc_pkg::FHC_DEF_AW,
    parameter int DW = fhc_pkg::FHC_DEF_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant,
    input  logic [AW-1:0] lo_bound,
    input  logic [AW-1:0] hi_bound,
    input  logic [AW-1:0] rd_commit_ptr,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] wr_ptr,
    output logic          full,
    output logic          empty,
    output logic [AW:0]   fill_count
);
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_next;
    logic          ptr_wraps;

    fhc_ptr_step #(.AW(AW)) u_step (
        .cur   (ptr_q),
        .lo    (lo_bound),
        .hi    (hi_bound),
        .nxt   (ptr_next),
        .wraps (ptr_wraps)
    );

    fhc_occupancy #(.AW(AW)) u_occ (
        .wptr  (ptr_q),
        .rptr  (rd_commit_ptr),
        .lo    (lo_bound),
        .hi    (hi_bound),
        .count (fill_count)
    );

    // Status and handshake decode.
    always_comb begin
        full      = (ptr_next == rd_commit_ptr);
        empty     = (ptr_q == rd_commit_ptr);
        in_ready  = grant && !full;
        mem_we    = in_valid && in_ready;
        mem_addr  = ptr_q;
        mem_wdata = in_data;
        wr_ptr    = ptr_q;
    end

    // Write pointer: reset to the low bound, step on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= lo_bound;
        else if (mem_we)
            ptr_q <= ptr_next;
    end
endmodule

// File: rtl/fhc_chk.sv
// fhc_chk: temporal checks on fifo_head_ctrl, attached by bind below.
// Assumes bounds are stable while reset is released.
module fhc_chk #(
    parameter int AW = fhc_pkg::FHC_DEF_AW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          grant,
    input logic [AW-1:0] lo_bound,
    input logic [AW-1:0] hi_bound,
    input logic [AW-1:0] wr_ptr,
    input logic          mem_we,
    input logic          full,
    input logic [AW:0]   fill_count
);
    // R3
    no_write_without_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> !mem_we);

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wr_ptr != hi_bound) |=> wr_ptr == $past(wr_ptr) + AW'(1));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |=> $stable(wr_ptr));

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wr_ptr == hi_bound) |=> wr_ptr == $past(lo_bound));

    // R6
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !mem_we);

    // R9
    full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> fill_count == {1'b0, hi_bound} - {1'b0, lo_bound});

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= {1'b0, hi_bound} - {1'b0, lo_bound});
endmodule

bind fifo_head_ctrl fhc_chk #(.AW(AW)) u_fhc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .lo_bound   (lo_bound),
    .hi_bound   (hi_bound),
    .wr_ptr     (wr_ptr),
    .mem_we     (mem_we),
    .full       (full),
    .fill_count (fill_count)
);

// File: tb/tb_fifo_head_ctrl.sv
// tb_fifo_head_ctrl: region sweeps with an arithmetic model of pointer,
// fullness and occupancy.
module tb_fifo_head_ctrl;
    localparam int AW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          grant = 1'b0;
    logic [AW-1:0] lo_bound = '0;
    logic [AW-1:0] hi_bound = '0;
    logic [AW-1:0] rd_commit_ptr = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [AW-1:0] wr_ptr;
    logic          full;
    logic          empty;
    logic [AW:0]   fill_count;

    int n_run = 0;
    int n_fail = 0;
    int lo, hi, mp, rp;
    string ptr_tag = "R1";

    always #10 clk = ~clk;

    fifo_head_ctrl #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .grant(grant), .lo_bound(lo_bound),
        .hi_bound(hi_bound), .rd_commit_ptr(rd_commit_ptr), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wr_ptr(wr_ptr),
        .full(full), .empty(empty), .fill_count(fill_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (lo=%0d hi=%0d)", tag, act, exp, lo, hi);
        end
    endtask

    function automatic int succ(input int p);
        return (p == hi) ? lo : p + 1;
    endfunction

    // One cycle: drive at the falling edge, check combinational and registered outputs, model the edge.
    task automatic step(input bit v, input bit g, input bit adv, input int d);
        int occ;
        bit e_full, e_rdy, e_we;
        @(negedge clk);
        if (adv && rp != mp) rp = succ(rp);
        in_valid = v; grant = g; in_data = DW'(d); rd_commit_ptr = AW'(rp);
        #2;
        chk(ptr_tag, int'(wr_ptr), mp);
        e_full = (succ(mp) == rp);
        e_rdy  = g && !e_full;
        e_we   = v && e_rdy;
        occ    = (mp >= rp) ? mp - rp : (hi - lo + 1) - (rp - mp);
        chk("R6", int'(full), int'(e_full));
        chk(g ? "R6" : "R3", int'(in_ready), int'(e_rdy));
        chk(g ? "R2" : "R3", int'(mem_we), int'(e_we));
        if (e_we) begin
            chk("R2", int'(mem_addr), mp);
            chk("R2", int'(mem_wdata), d & 255);
        end
        chk("R7", int'(empty), int'(mp == rp));
        chk("R8", int'(fill_count), occ);
        @(posedge clk);
        if (e_we) begin
            ptr_tag = (mp == hi) ? "R5" : "R4";
            mp = succ(mp);
        end else begin
            ptr_tag = "R4";
        end
    endtask

    task automatic run_cfg(input int l, input int h);
        lo = l; hi = h;
        @(negedge clk);
        rst_n = 1'b0; lo_bound = AW'(l); hi_bound = AW'(h);
        rp = l; rd_commit_ptr = AW'(l); in_valid = 1'b0; grant = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1", int'(wr_ptr), l);
        chk("R1", int'(empty), 1);
        chk("R1", int'(fill_count), 0);
        mp = l; ptr_tag = "R1";
        // Burst from empty, one denied grant on the way.
        for (int i = 0; i < h - l + 3; i++) step(1'b1, i != 1, 1'b0, i * 13 + l);
        @(negedge clk); #2;
        chk("R9", int'(full), 1);
        chk("R9", int'(fill_count), h - l);
        // Mixed traffic with wrap.
        for (int i = 0; i < 150; i++) step(i % 3 != 0, i % 5 != 2, (i % 4) < 2, i * 7 + h);
        // Drain by the reader only.
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b1, i);
        chk("R7", int'(empty), 1);
    endtask

    initial begin
        #(20 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        run_cfg(3, 9);   // R9 size 7
        run_cfg(0, 4);   // size 5
        run_cfg(5, 15);  // region ends at top address
        run_cfg(0, 15);  // power of two
        run_cfg(6, 6);   // single slot, always full
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule